// File: doc/BRIEF.md
# Cache Line Decay Controller

This block decides when each line of a cache has sat unused long enough to be put into a low-leakage standby state. It does not time each line with a wide timer. One shared counter divides the programmed decay interval into four equal periods and emits a tick at the end of each period. Every line keeps only a 2-bit saturating age that advances on these ticks and returns to zero whenever the line is touched. The standby vector it produces drives the power switches of both the data array and the tag array. Because tags sleep along with data, a lookup to a sleeping line must wait for the line to wake.

Two policies are available at run time. The history policy retires a line only when its own age saturates. The sweep policy ignores access history and sends every line to standby on every fourth tick, which is once per full decay interval. An access to a sleeping line raises a wake request in that same cycle and returns the line to the active state at the next clock edge. The decay interval is a live input. Any change to it restarts the shared counter, so the next period starts in a known phase.

Top module: `line_decay_ctrl`

## Requirements
- R1: With interval input I, the shared counter period is Q = I/4 cycles, where a value of Q = 0 is treated as 1. A tick occurs on the last cycle of each period. A line accessed on a restart edge and left idle under the history policy enters standby exactly 3*Q clock edges later.
- R2: Each line's age is 2 bits. It advances by one per tick and saturates at 3 without wrapping, including while the policy is being switched.
- R3: Under the history policy (policy input 0), a line enters standby at the tick on which its age reaches 3. A line in standby stays there until it is accessed.
- R4: Under the sweep policy (policy input 1), every fourth tick after a restart puts every line that is not accessed in that cycle into standby, whatever the line's age. Under this policy a line is never put into standby by its age alone.
- R5: An access to a line clears its age and its standby bit at the next clock edge. In the same cycle as the access, wake request bit i is 1 exactly when line i is accessed while in standby.
- R6: A change of the interval input seen at a clock edge restarts the shared counter and the sweep phase. That edge produces no tick.
- R7: Synchronous active-high reset leaves every line active with age zero and no wake request.
- R8: The tag standby output is equal to the data standby output for every line in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 1 | 0 selects the history policy, 1 selects the sweep policy |
| interval_i | input | IW | Decay interval in cycles; a multiple of 4 |
| access_i | input | N | One strobe per line, high in a cycle that touches the line |
| data_sleep_o | output | N | Standby request for each line's data storage |
| tag_sleep_o | output | N | Standby request for each line's tag storage |
| wake_req_o | output | N | Wake request for lines accessed while in standby |

## Verification
The bench builds the block with four lines and an 8-bit interval. This keeps the periods between 1 and 5 cycles, so the bench reaches saturation, sweeps and interval restarts many times in a short run. It steps through intervals 0, 4, 8, 12 and 20, and under each interval it runs both policies and a stretch that toggles the policy. With four lines, the bench can give an access pattern every combination of sleeping and active lines, including a line whose age saturates under the sweep policy and is then judged under the history policy.

// File: rtl/line_decay_pkg.sv
package line_decay_pkg;

    typedef enum logic {
        POL_HISTORY = 1'b0,
        POL_SWEEP   = 1'b1
    } decay_policy_e;

    localparam int unsigned AGE_W = 2;
    localparam logic [AGE_W-1:0] AGE_MAX = 2'd3;

    typedef struct packed {
        logic [AGE_W-1:0] age;
        logic             asleep;
    } line_state_t;

    // saturating increment of a line age
    function automatic logic [AGE_W-1:0] age_step(input logic [AGE_W-1:0] a);
        return (a == AGE_MAX) ? a : a + 2'd1;
    endfunction

endpackage

// File: rtl/decay_tick_gen.sv
module decay_tick_gen
    import line_decay_pkg::*;
#(
    parameter int unsigned IW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] interval_i,
    output logic          tick_o,
    output logic          sweep_o
);
    localparam int unsigned QW = IW - 2;
    localparam logic [QW-1:0] Q_ONE = QW'(1);

    logic [IW-1:0] iv_q;
    logic [QW-1:0] phase_q;
    logic [QW-1:0] phase_last;
    logic [QW-1:0] quarter;
    logic [1:0]    epoch_q;
    logic          changed;

    always_comb begin
        quarter    = interval_i[IW-1:2];
        phase_last = (quarter == '0) ? '0 : quarter - Q_ONE;
        changed    = (interval_i != iv_q);
        tick_o     = !changed && (phase_q == phase_last);
        sweep_o    = tick_o && (epoch_q == 2'd3);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iv_q    <= interval_i;
            phase_q <= '0;
            epoch_q <= 2'd0;
        end else begin
            iv_q <= interval_i;
            if (changed) begin
                phase_q <= '0;
                epoch_q <= 2'd0;
            end else if (tick_o) begin
                phase_q <= '0;
                epoch_q <= epoch_q + 2'd1;
            end else begin
                phase_q <= phase_q + Q_ONE;
            end
        end
    end

    // R1: the counter restarts from zero after a tick
    a_r1_wrap_after_tick: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (phase_q == '0));
    // R1: between ticks the counter steps by one
    a_r1_count_up: assert property (@(posedge clk) disable iff (rst)
        (!changed && !tick_o) |=> (phase_q == $past(phase_q) + Q_ONE));
    // R6: an interval change restarts phase and epoch
    a_r6_restart_on_change: assert property (@(posedge clk) disable iff (rst)
        changed |=> (phase_q == '0 && epoch_q == 2'd0));
    // R4: a sweep closes an epoch of four ticks
    a_r4_epoch_closes: assert property (@(posedge clk) disable iff (rst)
        sweep_o |=> (epoch_q == 2'd0));

endmodule

// File: rtl/decay_line.sv
module decay_line
    import line_decay_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  decay_policy_e policy_i,
    input  logic          tick_i,
    input  logic          sweep_i,
    input  logic          access_i,
    output logic          asleep_o,
    output logic          wake_o
);
    line_state_t      st_q, st_d;
    logic [AGE_W-1:0] age_nxt;

    always_comb begin
        st_d    = st_q;
        age_nxt = age_step(st_q.age);
        if (access_i) begin
            st_d.age    = '0;
            st_d.asleep = 1'b0;
        end else if (tick_i) begin
            st_d.age = age_nxt;
            if (policy_i == POL_HISTORY && age_nxt == AGE_MAX) st_d.asleep = 1'b1;
            if (policy_i == POL_SWEEP && sweep_i)              st_d.asleep = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{age: '0, asleep: 1'b0};
        else     st_q <= st_d;
    end

    assign asleep_o = st_q.asleep;
    assign wake_o   = access_i & st_q.asleep;

    // R5: an access clears age and standby at the next edge
    a_r5_access_clears: assert property (@(posedge clk) disable iff (rst)
        access_i |=> (st_q.age == '0 && !asleep_o));
    // R2: a saturated age does not wrap
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (st_q.age == AGE_MAX && !access_i) |=> (st_q.age == AGE_MAX));
    // R2: without tick or access the age holds
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (!access_i && !tick_i) |=> $stable(st_q.age));
    // R3: standby only ever begins on a tick
    a_r3_sleep_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep_o) |-> $past(tick_i));

endmodule

// File: rtl/line_decay_ctrl.sv
module line_decay_ctrl
    import line_decay_pkg::*;
#(
    parameter int unsigned N  = 64,
    parameter int unsigned IW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          policy_i,
    input  logic [IW-1:0] interval_i,
    input  logic [N-1:0]  access_i,
    output logic [N-1:0]  data_sleep_o,
    output logic [N-1:0]  tag_sleep_o,
    output logic [N-1:0]  wake_req_o
);
    logic          tick;
    logic          sweep;
    decay_policy_e pol;
    logic [N-1:0]  asleep;

    assign pol = decay_policy_e'(policy_i);

    decay_tick_gen #(.IW(IW)) u_tick (
        .clk        (clk),
        .rst        (rst),
        .interval_i (interval_i),
        .tick_o     (tick),
        .sweep_o    (sweep)
    );

    for (genvar i = 0; i < N; i++) begin : g_line
        decay_line u_line (
            .clk      (clk),
            .rst      (rst),
            .policy_i (pol),
            .tick_i   (tick),
            .sweep_i  (sweep),
            .access_i (access_i[i]),
            .asleep_o (asleep[i]),
            .wake_o   (wake_req_o[i])
        );
    end

    // data and tags share one standby decision per line
    assign data_sleep_o = asleep;
    assign tag_sleep_o  = asleep;

    // R7: reset leaves every line active
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (data_sleep_o == '0));
    // R5: a wake request always comes with an access
    a_r5_wake_needs_access: assert property (@(posedge clk) disable iff (rst)
        (wake_req_o & ~access_i) == '0);

endmodule

// File: tb/line_decay_ctrl_tb.sv
module line_decay_ctrl_tb;
    localparam int N  = 4;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          policy;
    logic [IW-1:0] interval;
    logic [N-1:0]  acc;
    logic [N-1:0]  data_sleep, tag_sleep, wake;

    always #5 clk = ~clk;

    line_decay_ctrl #(.N(N), .IW(IW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .policy_i     (policy),
        .interval_i   (interval),
        .access_i     (acc),
        .data_sleep_o (data_sleep),
        .tag_sleep_o  (tag_sleep),
        .wake_req_o   (wake)
    );

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R7";

    // reference state
    int            cnt;
    logic [1:0]    m_age [N];
    logic [N-1:0]  m_sl;
    logic [1:0]    m_ep;
    logic [IW-1:0] iv_prev;
    logic [15:0]   lfsr = 16'hACE1;

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        cnt = 0; m_ep = 2'd0; m_sl = '0; iv_prev = interval;
        for (int i = 0; i < N; i++) m_age[i] = 2'd0;
    endtask

    task automatic model_edge(input logic [N-1:0] a);
        int q; logic tk, sw;
        q = int'(interval) / 4;
        if (q == 0) q = 1;
        if (interval != iv_prev) begin
            cnt = 0; tk = 1'b0; m_ep = 2'd0; iv_prev = interval;
        end else begin
            cnt++; tk = ((cnt % q) == 0);
        end
        sw = tk && (m_ep == 2'd3);
        for (int i = 0; i < N; i++) begin
            if (a[i]) begin
                m_age[i] = 2'd0; m_sl[i] = 1'b0;
            end else if (tk) begin
                if (m_age[i] != 2'd3) m_age[i] = m_age[i] + 2'd1;
                if (!policy && m_age[i] == 2'd3) m_sl[i] = 1'b1;
                if (policy && sw) m_sl[i] = 1'b1;
            end
        end
        if (tk) m_ep = m_ep + 2'd1;
    endtask

    // called at a negative edge
    task automatic cyc(input logic [N-1:0] a);
        acc = a;
        #1;
        check("R5 wake", wake, a & m_sl);
        @(posedge clk);
        model_edge(a);
        @(negedge clk);
        check(cur_tag, data_sleep, m_sl);
        check("R8 tag", tag_sleep, data_sleep);
    endtask

    function automatic logic [N-1:0] pick();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[9:5] == 5'd0) return '1;
        if (lfsr[2:0] == 3'd0) return N'(1) << lfsr[4:3];
        return '0;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [IW-1:0] ivs [5] = '{8'd0, 8'd4, 8'd8, 8'd12, 8'd20};
        rst = 1'b1; policy = 1'b0; interval = 8'd12; acc = '0;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 1'b0;
        #1;
        check("R7 sleep", data_sleep, '0);
        check("R7 tag", tag_sleep, '0);
        check("R7 wake", wake, '0);
        cur_tag = "R3";
        for (int k = 0; k < 30; k++) cyc(pick());

        for (int v = 0; v < 5; v++) begin
            int q, k;
            q = int'(ivs[v]) / 4;
            if (q == 0) q = 1;
            // R6 restart with every line touched, then R1 latency
            cur_tag = "R6";
            policy = 1'b0;
            interval = ivs[v];
            cyc('1);
            cur_tag = "R1";
            k = 0;
            for (int j = 1; j <= 64; j++) begin
                cyc('0);
                if (data_sleep[0]) begin k = j; break; end
            end
            checks++;
            if (k != 3 * q) begin
                fails++;
                $display("FAIL R1 latency actual=%0d expected=%0d", k, 3 * q);
            end
            cur_tag = "R3";
            for (int j = 0; j < 40; j++) cyc(pick());
            // R2 policy toggling with saturated ages
            cur_tag = "R2";
            for (int j = 0; j < 48; j++) begin
                if (j % 7 == 0) policy = ~policy;
                cyc(pick());
            end
            cur_tag = "R4";
            policy = 1'b1;
            for (int j = 0; j < 80; j++) cyc(pick());
            // R6 mid-period change back and forth
            cur_tag = "R6";
            interval = ivs[(v + 1) % 5];
            cyc('0);
            interval = ivs[v];
            for (int j = 0; j < 12; j++) cyc(pick());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule